// File: doc/BRIEF.md
# Memory-Mapped Bus Arbiter with Region Wait States

This block connects a processor's single memory port to three kinds of slave: a read-only region, a read/write region and a row of peripherals. On each access it decodes the word address and picks one slave. For the two memory regions it runs a wait-state counter, with a separate count for each region, and then hands back the stored word. For a peripheral it raises that peripheral's own request line and forwards the local offset, the write flag and the write data. It then waits for that peripheral's ready line. An address that hits no slave is answered at once with zero data, so the processor never stalls on a bad pointer.

The two memory regions are latency stubs with storage that can be mapped to block RAM. They stand in for slow serial memories. Only one access is in flight at a time. The processor sees one ready pulse per access, and read data arrives with it.

Top module: `mba_bus_arbiter`

## Requirements
- R1: Word addresses are 31 bits. [0, ROM_DEPTH) selects the read-only region, which defaults to 128 words. The next RAM_DEPTH words select the read/write region, which defaults to 256 words, so its top is 383. From 384 upward, peripheral i owns the 2^SPAN_W words (8 by default) starting at its base in PER_BASES, which defaults to 384, 392 and 400. The lowest index wins when bases overlap. All other addresses are unmapped.
- R2: A read of read-only word k returns ROM_FILL + k, where ROM_FILL defaults to 0xC0DE0000. If the request is sampled in cycle c, cpu_ready is high in cycle c+1+ROM_WAIT. ROM_WAIT defaults to 3.
- R3: A word written to the read/write region is returned by a later read of the same address. With RAM_WAIT = 0 (the default), cpu_ready for both reads and writes is high in cycle c+1.
- R4: A write to the read-only region completes with the usual latency but does not change its content.
- R5: A peripheral access drives per_req[i] high from cycle c+1. It stays high through the first cycle in which per_ready[i] is sampled high. per_addr carries address minus base, and per_we and per_wdata carry the access. cpu_ready and the captured per_rdata word appear in the following cycle.
- R6: An unmapped access gives cpu_ready in cycle c+1 with cpu_rdata = 0 and raises no per_req line.
- R7: While an access is in flight, cpu_req is ignored: it starts no second access, writes nothing and produces no extra ready.
- R8: cpu_ready is a single-cycle pulse, and cpu_rdata is valid in that same cycle.
- R9: Synchronous reset drops any access in flight. After reset, cpu_ready and per_req are low and no late ready appears.
- R10: A per_ready pulse from a peripheral whose request line is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 31 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| per_req | output | N_PER | One-hot peripheral request, held until ready |
| per_we | output | 1 | Write flag to peripherals |
| per_addr | output | SPAN_W | Offset inside the selected peripheral |
| per_wdata | output | 32 | Write data to peripherals |
| per_rdata | input | N_PER*32 | Read data, peripheral i in bits [32i+31:32i] |
| per_ready | input | N_PER | Peripheral completion |

## Verification
Each result has a fixed due cycle, counted from the clock edge that samples the request:
- read-only region: ROM_WAIT+1 cycles later;
- read/write region and unmapped addresses: one cycle later;
- peripheral: one cycle after the edge that sees its ready line.

The bench drives on falling edges and counts falling edges until cpu_ready. It compares that count with the due value and reads cpu_rdata in that same half cycle. One falling edge later it confirms that the pulse has ended. The peripheral model answers after a known per-index delay, so the due cycle for a peripheral access is known in advance.

// File: rtl/mba_pkg.sv
package mba_pkg;
  localparam int ADDR_W = 31;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RGN_ROM  = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_PER  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/mba_decode.sv
module mba_decode
  import mba_pkg::*;
#(
  parameter int ROM_DEPTH = 128,
  parameter int RAM_DEPTH = 256,
  parameter int N_PER     = 3,
  parameter int SPAN_W    = 3,
  parameter int IDX_W     = 2,
  parameter logic [N_PER*ADDR_W-1:0] PER_BASES = {31'd400, 31'd392, 31'd384}
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  per_idx
);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(ROM_DEPTH);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(ROM_DEPTH + RAM_DEPTH);

  logic [N_PER-1:0] hit;
  logic             any_hit;

  for (genvar i = 0; i < N_PER; i++) begin : g_hit
    assign hit[i] = (addr[ADDR_W-1:SPAN_W] ==
                     PER_BASES[i*ADDR_W+SPAN_W +: ADDR_W-SPAN_W]);
  end

  // lowest index wins on overlap
  always_comb begin
    per_idx = '0;
    any_hit = 1'b0;
    for (int i = N_PER - 1; i >= 0; i--) begin
      if (hit[i]) begin
        per_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (addr < RAM_LO)      region = RGN_ROM;
    else if (addr < RAM_HI) region = RGN_RAM;
    else if (any_hit)       region = RGN_PER;
    else                    region = RGN_NONE;
  end
endmodule

// File: rtl/mba_wait_mem.sv
module mba_wait_mem
  import mba_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int WAIT     = 0,
  parameter bit WRITABLE = 1'b1,
  parameter logic [DATA_W-1:0] FILL_BASE = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = (WAIT < 2) ? 1 : $clog2(WAIT + 1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     idx_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              fire;
  logic [AW-1:0]     acc_idx;
  logic              acc_we;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = FILL_BASE + DATA_W'(i);
  end

  always_comb begin
    if (WAIT == 0) fire = start;
    else           fire = active && (cnt == CW'(1));
    acc_idx   = active ? idx_q   : idx;
    acc_we    = active ? we_q    : we;
    acc_wdata = active ? wdata_q : wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= fire;
      if (start && WAIT != 0) begin
        active <= 1'b1;
        cnt    <= CW'(WAIT);
      end else if (active) begin
        if (cnt == CW'(1)) active <= 1'b0;
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      idx_q   <= idx;
      we_q    <= we;
      wdata_q <= wdata;
    end
  end

  // single-port block RAM shape: registered read, gated write
  always_ff @(posedge clk) begin
    if (fire) begin
      if (acc_we && WRITABLE) mem[acc_idx] <= acc_wdata;
      rdata <= mem[acc_idx];
    end
  end

  AST_NO_START_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    active |-> !start);  // R7
  AST_ZERO_WAIT_NEXT: assert property (@(posedge clk) disable iff (rst)
    start |=> (done == (WAIT == 0)));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
endmodule

// File: rtl/mba_bus_arbiter.sv
module mba_bus_arbiter
  import mba_pkg::*;
#(
  parameter int ROM_DEPTH = 128,
  parameter int RAM_DEPTH = 256,
  parameter int ROM_WAIT  = 3,
  parameter int RAM_WAIT  = 0,
  parameter int N_PER     = 3,
  parameter int SPAN_W    = 3,
  parameter logic [N_PER*ADDR_W-1:0] PER_BASES = {31'd400, 31'd392, 31'd384},
  parameter logic [DATA_W-1:0] ROM_FILL = 32'hC0DE_0000,
  parameter logic [DATA_W-1:0] RAM_FILL = 32'h0000_0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic [N_PER-1:0]        per_req,
  output logic                    per_we,
  output logic [SPAN_W-1:0]       per_addr,
  output logic [DATA_W-1:0]       per_wdata,
  input  logic [N_PER*DATA_W-1:0] per_rdata,
  input  logic [N_PER-1:0]        per_ready
);
  localparam int IDX_W  = (N_PER > 1) ? $clog2(N_PER) : 1;
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  region_e           dec_rgn;
  logic [IDX_W-1:0]  dec_idx;
  logic              busy_q;
  region_e           sel_q;
  logic [IDX_W-1:0]  pidx_q;
  logic              accept;
  logic              rom_start, ram_start;
  logic              rom_done, ram_done;
  logic [DATA_W-1:0] rom_rdata, ram_rdata;
  logic              per_hit, per_done_q, none_done_q;
  logic [DATA_W-1:0] per_data_q;

  mba_decode #(
    .ROM_DEPTH(ROM_DEPTH), .RAM_DEPTH(RAM_DEPTH), .N_PER(N_PER),
    .SPAN_W(SPAN_W), .IDX_W(IDX_W), .PER_BASES(PER_BASES)
  ) u_decode (
    .addr(cpu_addr), .region(dec_rgn), .per_idx(dec_idx)
  );

  assign accept    = !busy_q && cpu_req;
  assign rom_start = accept && (dec_rgn == RGN_ROM);
  assign ram_start = accept && (dec_rgn == RGN_RAM);

  mba_wait_mem #(
    .DEPTH(ROM_DEPTH), .WAIT(ROM_WAIT), .WRITABLE(1'b0), .FILL_BASE(ROM_FILL)
  ) u_rom (
    .clk(clk), .rst(rst), .start(rom_start), .we(cpu_we),
    .idx(cpu_addr[ROM_AW-1:0]), .wdata(cpu_wdata),
    .done(rom_done), .rdata(rom_rdata)
  );

  mba_wait_mem #(
    .DEPTH(RAM_DEPTH), .WAIT(RAM_WAIT), .WRITABLE(1'b1), .FILL_BASE(RAM_FILL)
  ) u_ram (
    .clk(clk), .rst(rst), .start(ram_start), .we(cpu_we),
    .idx(RAM_AW'(cpu_addr - ADDR_W'(ROM_DEPTH))), .wdata(cpu_wdata),
    .done(ram_done), .rdata(ram_rdata)
  );

  assign per_hit = |(per_req & per_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      sel_q       <= RGN_NONE;
      pidx_q      <= '0;
      per_req     <= '0;
      per_done_q  <= 1'b0;
      none_done_q <= 1'b0;
    end else begin
      per_done_q  <= per_hit;
      none_done_q <= accept && (dec_rgn == RGN_NONE);
      if (accept) begin
        busy_q <= 1'b1;
        sel_q  <= dec_rgn;
        pidx_q <= dec_idx;
        if (dec_rgn == RGN_PER) per_req <= N_PER'(1) << dec_idx;
      end else begin
        if (cpu_ready) busy_q <= 1'b0;
        if (per_hit) per_req <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && dec_rgn == RGN_PER) begin
      per_we    <= cpu_we;
      per_addr  <= cpu_addr[SPAN_W-1:0];
      per_wdata <= cpu_wdata;
    end
    if (per_hit) per_data_q <= per_rdata[DATA_W*int'(pidx_q) +: DATA_W];
  end

  assign cpu_ready = rom_done | ram_done | per_done_q | none_done_q;

  always_comb begin
    unique case (sel_q)
      RGN_ROM: cpu_rdata = rom_rdata;
      RGN_RAM: cpu_rdata = ram_rdata;
      RGN_PER: cpu_rdata = per_data_q;
      default: cpu_rdata = '0;
    endcase
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);  // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_done, ram_done, per_done_q, none_done_q}));  // R8
  AST_PER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_req));  // R5
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((|per_req) && !per_hit) |=> (per_req == $past(per_req)));  // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && dec_rgn == RGN_NONE) |=> (cpu_ready && cpu_rdata == '0 && per_req == '0));  // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !cpu_ready) |=> ($stable(sel_q) && busy_q));  // R7
  AST_STRAY_READY: assert property (@(posedge clk) disable iff (rst)
    (per_req == '0) |=> !per_done_q);  // R10
endmodule

// File: tb/mba_bus_arbiter_bench.sv
module mba_bus_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [30:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic [NP-1:0]    per_req;
  logic             per_we;
  logic [2:0]       per_addr;
  logic [31:0]      per_wdata;
  logic [NP*32-1:0] per_rdata;
  logic [NP-1:0]    per_ready = '0;
  logic [NP-1:0]    stray = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit per_seen = 0;
  int pcnt [NP];
  logic [31:0] last_wdata [NP];
  logic [2:0]  last_off [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  mba_bus_arbiter u_mba_bus_arbiter (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .per_req(per_req), .per_we(per_we),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_ready(per_ready)
  );

  // peripheral i answers i+1 cycles after its request rises
  always @(negedge clk) begin
    if (per_req != '0) per_seen = 1;
    for (int i = 0; i < NP; i++) begin
      if (per_req[i]) pcnt[i] = pcnt[i] + 1;
      else            pcnt[i] = 0;
      per_ready[i] = (per_req[i] && pcnt[i] == i + 1) || stray[i];
      per_rdata[i*32 +: 32] = 32'hBE00_0000 | (32'(i) << 8) | 32'(per_addr);
      if (per_req[i] && pcnt[i] == i + 1 && per_we) begin
        last_wdata[i] = per_wdata;
        last_off[i]   = per_addr;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [30:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    lat = 1;
    while (!cpu_ready && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    check("R8 ready pulse ends", 32'(cpu_ready), 32'd0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R9 reset cpu_ready", 32'(cpu_ready), 32'd0);
    check("R9 reset per_req", 32'(per_req), 32'd0);
    rst = 0;
  endtask

  task automatic t_rom_read();
    logic [31:0] rd; int lat;
    access(0, 31'd0, 0, rd, lat);
    check("R2 rom word 0", rd, 32'hC0DE_0000);
    check("R2 rom latency", 32'(lat), 32'd4);
    access(0, 31'd127, 0, rd, lat);
    check("R2 rom word 127", rd, 32'hC0DE_007F);
    check("R1 rom top latency", 32'(lat), 32'd4);
  endtask

  task automatic t_ram_rw();
    logic [31:0] rd; int lat;
    access(1, 31'd128, 32'hA1B2_C3D4, rd, lat);
    check("R3 ram write latency", 32'(lat), 32'd1);
    access(1, 31'd383, 32'h0BAD_F00D, rd, lat);
    access(0, 31'd128, 0, rd, lat);
    check("R3 ram read 128", rd, 32'hA1B2_C3D4);
    check("R3 ram read latency", 32'(lat), 32'd1);
    access(0, 31'd383, 0, rd, lat);
    check("R1 ram read 383", rd, 32'h0BAD_F00D);
  endtask

  task automatic t_rom_write();
    logic [31:0] rd; int lat;
    access(1, 31'd20, 32'hFFFF_FFFF, rd, lat);
    check("R4 rom write latency", 32'(lat), 32'd4);
    access(0, 31'd20, 0, rd, lat);
    check("R4 rom unchanged", rd, 32'hC0DE_0014);
  endtask

  task automatic t_periph();
    logic [31:0] rd; int lat;
    access(0, 31'd386, 0, rd, lat);
    check("R5 per0 data", rd, 32'hBE00_0002);
    check("R5 per0 latency", 32'(lat), 32'd2);
    access(0, 31'd407, 0, rd, lat);
    check("R5 per2 data", rd, 32'hBE00_0207);
    check("R5 per2 latency", 32'(lat), 32'd4);
    access(1, 31'd395, 32'h1234_5678, rd, lat);
    check("R5 per1 write data", last_wdata[1], 32'h1234_5678);
    check("R5 per1 write offset", 32'(last_off[1]), 32'd3);
    check("R5 per1 write latency", 32'(lat), 32'd3);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; int lat;
    per_seen = 0;
    access(0, 31'd408, 0, rd, lat);
    check("R6 unmapped data", rd, 32'd0);
    check("R6 unmapped latency", 32'(lat), 32'd1);
    access(0, 31'h7FFF_FFFF, 0, rd, lat);
    check("R6 top address data", rd, 32'd0);
    check("R6 no per_req", 32'(per_seen), 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] rd; int lat; int extra;
    access(1, 31'd200, 32'h1111_2222, rd, lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 31'd10;
    @(negedge clk);
    cpu_we = 1; cpu_addr = 31'd200; cpu_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    cpu_req = 0;
    @(negedge clk);
    check("R7 first ready on time", 32'(cpu_ready), 32'd1);
    check("R7 first data", cpu_rdata, 32'hC0DE_000A);
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (cpu_ready) extra++;
    end
    check("R7 no extra ready", 32'(extra), 32'd0);
    access(0, 31'd200, 0, rd, lat);
    check("R7 ram not written", rd, 32'h1111_2222);
  endtask

  task automatic t_stray();
    int seen = 0;
    @(negedge clk);
    stray = 3'b100;
    @(negedge clk);
    stray = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (cpu_ready) seen++;
    end
    check("R10 stray ready ignored", 32'(seen), 32'd0);
  endtask

  task automatic t_reset_midflight();
    logic [31:0] rd; int lat; int seen = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 31'd5;
    @(negedge clk);
    cpu_req = 0;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (cpu_ready) seen++;
    end
    check("R9 no late ready", 32'(seen), 32'd0);
    access(0, 31'd5, 0, rd, lat);
    check("R9 access after reset", rd, 32'hC0DE_0005);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      pcnt[i] = 0; last_wdata[i] = '0; last_off[i] = '0;
    end
    per_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_rom_read();
    t_ram_rw();
    t_rom_write();
    t_periph();
    t_unmapped();
    t_busy_ignore();
    t_stray();
    t_reset_midflight();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule